// File: doc/BRIEF.md
# Pulse-Sequenced Program Datapath

This block is a small, fixed program turned into a clocked circuit, with control carried by single-cycle pulses instead of a central state machine. A pulse on `start` enters the first statement. Each statement stage holds one delay flop, and that flop passes the pulse to the next stage one cycle later. A two-way conditional steers the pulse into one of two branch stages. A while-loop sends the pulse either back into its body or out towards `finish`. Every stage that writes a variable gives a write enable and a data term already gated by that enable. The variable registers are fed by OR-ing these terms from all of their writers.

The program is fixed. It loads `acc` from `din_a`. It then either adds `din_b` to `acc` (`sel` = 1) or XORs `din_b` into `acc` (`sel` = 0). It loads `cnt` from `trip`. While `cnt` is non-zero it adds `din_b` to `acc` and then decrements `cnt`. When the loop exits, the block raises `finish` for one cycle. Control pins are plain levels and pulses. The data inputs (`sel`, `din_a`, `din_b`, `trip`) carry no handshake and must be held stable from the `start` pulse until `finish`. The environment must not pulse `start` again before `finish`.

Top module: `pulse_prog_ctrl`

## Requirements
- R1: After reset `finish` is 0, and it stays 0 for as long as no `start` pulse arrives.
- R2: The first statement loads `acc` with `din_a` one clock edge after `start`. The result is visible through the final `acc` value.
- R3: When `sel` = 1 the conditional applies `acc + din_b`, and when `sel` = 0 it applies `acc ^ din_b`. Exactly one branch executes in each run. All arithmetic is modulo 2^W.
- R4: The loop body runs exactly `trip` times. Each pass adds `din_b` to `acc` and then decrements `cnt`. The final `acc` is the branch result plus `trip*din_b`, modulo 2^W.
- R5: Let `start` be high in cycle t. Then `finish` is high in cycle t+4+2*`trip`. With `trip` = 0 this is t+4, and `acc` keeps the branch result.
- R6: `finish` is high for exactly one cycle per run.
- R7: At `finish`, `cnt` reads 0.
- R8: While no run is active, changes on `sel`, `din_a`, `din_b` and `trip` leave `acc` and `cnt` unchanged.
- R9: At most one stage control pulse is high in any cycle. At most one writer enable per variable register is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control flops |
| start | input | 1 | One-cycle pulse that starts the program |
| sel | input | 1 | Branch select: 1 adds, 0 XORs |
| din_a | input | W | Initial value for `acc` |
| din_b | input | W | Operand for the branch and the loop body |
| trip | input | CW | Loop iteration count |
| finish | output | 1 | One-cycle completion pulse |
| acc_q | output | W | Accumulator register |
| cnt_q | output | CW | Loop counter register |

## Verification
The hardest situation to reach is the loop exit. It depends on a register value that the loop body itself wrote two cycles earlier, so an off-by-one in the recirculation path only appears for particular iteration counts. The stimulus sweeps every `trip` value from 0 to its maximum for both branch selections and with several operand pairs. Each run checks the exact finish cycle against 4+2*`trip`, so both the zero-iteration bypass and the longest loop are covered. Between runs the inputs are changed while the block is idle, to show that no writer enable leaks.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  // writer slots on the accumulator merge
  localparam int ACC_LOAD   = 0;
  localparam int ACC_ADD    = 1;
  localparam int ACC_XOR    = 2;
  localparam int ACC_LOOP   = 3;
  localparam int ACC_NWR    = 4;
  // writer slots on the counter merge
  localparam int CNT_INIT   = 0;
  localparam int CNT_DEC    = 1;
  localparam int CNT_NWR    = 2;
endpackage

// File: rtl/ps_stage.sv
// One statement stage: a delay flop for the control pulse plus the
// enable-gated data term it hands to a merged register.
module ps_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] value,
  output logic         done,
  output logic         we,
  output logic [W-1:0] wd
);
  assign we = go;
  assign wd = value & {W{go}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= go;
  end
endmodule

// File: rtl/ps_merge.sv
// Variable register shared by N writers: enable and data are OR-merged.
module ps_merge #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic              clk,
  input  logic [N-1:0]      we,
  input  logic [N-1:0][W-1:0] wd,
  output logic [W-1:0]      q
);
  logic [N:0][W-1:0] chain;
  logic              en;

  assign chain[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | wd[i];
  end
  assign en = |we;

  always_ff @(posedge clk) begin
    if (en) q <= chain[N];
  end
endmodule

// File: rtl/ps_steer.sv
// Pulse steering: used both for the two-way conditional and for the
// loop head (entry pulse OR body return, then test).
module ps_steer (
  input  logic enter,
  input  logic back,
  input  logic cond,
  output logic on_true,
  output logic on_false
);
  logic p;
  assign p        = enter | back;
  assign on_true  = p & cond;
  assign on_false = p & ~cond;
endmodule

// File: rtl/pulse_prog_ctrl.sv
module pulse_prog_ctrl #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel,
  input  logic [W-1:0]  din_a,
  input  logic [W-1:0]  din_b,
  input  logic [CW-1:0] trip,
  output logic          finish,
  output logic [W-1:0]  acc_q,
  output logic [CW-1:0] cnt_q
);
  import pulse_pkg::*;

  logic [ACC_NWR-1:0]         acc_we;
  logic [ACC_NWR-1:0][W-1:0]  acc_wd;
  logic [CNT_NWR-1:0]         cnt_we;
  logic [CNT_NWR-1:0][CW-1:0] cnt_wd;

  logic ld_done, add_go, xor_go, add_done, xor_done, br_done;
  logic ini_done, body_go, leave, bodya_done, bodyb_done;
  logic [6:0] ctl_pulses;

  // statement 1: acc := din_a
  ps_stage #(.W(W)) u_load (
    .clk(clk), .rst_n(rst_n), .go(start), .value(din_a),
    .done(ld_done), .we(acc_we[ACC_LOAD]), .wd(acc_wd[ACC_LOAD]));

  // conditional on sel
  ps_steer u_cond (
    .enter(ld_done), .back(1'b0), .cond(sel),
    .on_true(add_go), .on_false(xor_go));

  ps_stage #(.W(W)) u_add (
    .clk(clk), .rst_n(rst_n), .go(add_go), .value(acc_q + din_b),
    .done(add_done), .we(acc_we[ACC_ADD]), .wd(acc_wd[ACC_ADD]));

  ps_stage #(.W(W)) u_xor (
    .clk(clk), .rst_n(rst_n), .go(xor_go), .value(acc_q ^ din_b),
    .done(xor_done), .we(acc_we[ACC_XOR]), .wd(acc_wd[ACC_XOR]));

  assign br_done = add_done | xor_done;

  // cnt := trip
  ps_stage #(.W(CW)) u_init (
    .clk(clk), .rst_n(rst_n), .go(br_done), .value(trip),
    .done(ini_done), .we(cnt_we[CNT_INIT]), .wd(cnt_wd[CNT_INIT]));

  // loop head: while cnt != 0
  ps_steer u_loop (
    .enter(ini_done), .back(bodyb_done), .cond(cnt_q != '0),
    .on_true(body_go), .on_false(leave));

  // body part A: acc := acc + din_b
  ps_stage #(.W(W)) u_body_a (
    .clk(clk), .rst_n(rst_n), .go(body_go), .value(acc_q + din_b),
    .done(bodya_done), .we(acc_we[ACC_LOOP]), .wd(acc_wd[ACC_LOOP]));

  // body part B: cnt := cnt - 1
  ps_stage #(.W(CW)) u_body_b (
    .clk(clk), .rst_n(rst_n), .go(bodya_done), .value(cnt_q - 1'b1),
    .done(bodyb_done), .we(cnt_we[CNT_DEC]), .wd(cnt_wd[CNT_DEC]));

  // composite finish delay element
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) finish <= 1'b0;
    else        finish <= leave;
  end

  ps_merge #(.W(W), .N(ACC_NWR)) u_acc (
    .clk(clk), .we(acc_we), .wd(acc_wd), .q(acc_q));

  ps_merge #(.W(CW), .N(CNT_NWR)) u_cnt (
    .clk(clk), .we(cnt_we), .wd(cnt_wd), .q(cnt_q));

  assign ctl_pulses = {ld_done, add_done, xor_done, ini_done,
                       bodya_done, bodyb_done, finish};
endmodule

// File: rtl/pulse_prog_chk.sv
module pulse_prog_chk #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          finish,
  input logic [CW-1:0] cnt_q,
  input logic [3:0]    acc_we,
  input logic [1:0]    cnt_we,
  input logic [6:0]    ctl_pulses
);
  a_r6_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);

  a_r7_cnt_zero_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (cnt_q == '0));

  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_pulses));

  a_r9_acc_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_we));

  a_r9_cnt_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_we));

  // R8: with no pulse in flight the counter register cannot move
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pulses == '0 && cnt_we == '0) |=> $stable(cnt_q));
endmodule

bind pulse_prog_ctrl pulse_prog_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .finish(finish), .cnt_q(cnt_q),
  .acc_we(acc_we), .cnt_we(cnt_we), .ctl_pulses(ctl_pulses));

// File: tb/tb_pulse_prog_ctrl.sv
module tb_pulse_prog_ctrl;
  localparam int W  = 8;
  localparam int CW = 4;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sel = 1'b0;
  logic [W-1:0]  din_a = '0;
  logic [W-1:0]  din_b = '0;
  logic [CW-1:0] trip = '0;
  logic          finish;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  pulse_prog_ctrl #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel),
    .din_a(din_a), .din_b(din_b), .trip(trip),
    .finish(finish), .acc_q(acc_q), .cnt_q(cnt_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  initial begin
    while (cyc < 150000 && !done_flag) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic run(input logic s, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [CW-1:0] n);
    logic [W-1:0] exp_acc;
    int cycles;
    exp_acc = s ? W'(a + b) : (a ^ b);
    for (int k = 0; k < int'(n); k++) exp_acc = W'(exp_acc + b);
    @(negedge clk);
    sel = s; din_a = a; din_b = b; trip = n; start = 1'b1;
    cycles = 0;
    do begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      start = 1'b0;
    end while (!finish && cycles < 80);
    check(n == 0 ? "R5 zero-trip latency" : "R5 latency", cycles, 4 + 2 * int'(n));
    check(s ? "R3/R4 add path acc" : "R3/R4 xor path acc", int'(acc_q), int'(exp_acc));
    check("R7 cnt zero", int'(cnt_q), 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 finish one cycle", int'(finish), 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 finish in reset", int'(finish), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      din_a = W'(i * 37); trip = CW'(i);
      check("R1 no finish without start", int'(finish), 0);
    end

    // R2: direct load observable when branch is xor with b=0 and no loop
    run(1'b0, 8'hC3, 8'h00, '0);
    check("R2 load only", int'(acc_q), 'hC3);

    // main sweep: both branches, every trip value, a few operand pairs
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < (1 << CW); n++) begin
        for (int p = 0; p < 3; p++) begin
          logic [W-1:0] a;
          logic [W-1:0] b;
          a = W'(8'h5A ^ (n * 17) + p * 91);
          b = W'(p * 53 + n * 7 + 1);
          run(s[0], a, b, CW'(n));
          // R8: idle input changes must leave registers unchanged
          if (p == 1) begin
            logic [W-1:0] hold_acc;
            logic [CW-1:0] hold_cnt;
            hold_acc = acc_q;
            hold_cnt = cnt_q;
            for (int k = 0; k < 3; k++) begin
              @(negedge clk);
              sel = ~sel; din_a = ~din_a; din_b = W'(din_b + 29); trip = ~trip;
            end
            @(negedge clk);
            check("R8 idle acc hold", int'(acc_q), int'(hold_acc));
            check("R8 idle cnt hold", int'(cnt_q), int'(hold_cnt));
          end
        end
      end
    end

    // boundary: maximum operand wrap with maximum trip count
    run(1'b1, 8'hFF, 8'hFF, CW'((1 << CW) - 1));

    done_flag = 1'b1;
    summary();
  end
endmodule